// File: doc/BRIEF.md
# Sixteen-Line Digital Input/Output Controller

This block is a byte-wide register slave that drives sixteen output lines and samples sixteen input lines. Software reaches eight byte locations through a simple synchronous bus: a 3-bit address, one read strobe, one write strobe, write data and read data. The output lines hold whatever was last written to two output latches. The input lines pass through a two-flop synchronizer and an optional stability filter before software sees them.

Any input that changes level, rising or falling, can raise one shared, level-high interrupt. The control registers act as commands. A read of the interrupt-control location switches interrupts on, and a write to it switches them off. A read of the filter-control location switches the filters on, and a write to it switches them off. Any write to the low input location clears every recorded change. Software uses a status byte to tell which input byte changed and whether this block is the interrupt source.

Top module: `dio16_top`

## Requirements
- R1: After reset, pinOut is 0, irqOut is 0, interrupts and filters are off, and a read of offset 6 returns 0x00.
- R2: A write to offset 0 loads pinOut[7:0] and a write to offset 4 loads pinOut[15:8]. Reads of offsets 0 and 4 return those latches. pinOut changes only on such writes.
- R3: A read of offset 1 returns the accepted level of inputs 7:0 and a read of offset 5 returns inputs 15:8. With the filter off, a pinIn change is accepted on the third rising clock edge after it is applied.
- R4: Any read of offset 2 turns interrupts on. Any write to offset 2 turns them off. irqOut is high exactly while interrupts are on and a change is recorded.
- R5: Any read of offset 3 turns the filter on and any write to offset 3 turns it off. While the filter is on, a synchronized input must differ from its accepted value for FILT_LEN (default 4) consecutive clocks before the new level is accepted, so shorter pulses are dropped.
- R6: While interrupts are on, an accepted change in either direction on inputs 7:0 sets status bit 0, and one on inputs 15:8 sets status bit 1. Status bit 2 reads as the OR of bits 0 and 1, which is the pending flag. Bits 7:3 read 0. Changes accepted while interrupts are off are not recorded.
- R7: A write of any data to offset 1 clears status bits 0 and 1. A change accepted in the same cycle as the clear is still recorded.
- R8: Writes to offsets 5, 6 and 7 change nothing that is visible at the ports. A read of offset 7 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register byte offset |
| busRd | input | 1 | Read strobe; read side effects apply at the clock edge |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| pinIn | input | 16 | Asynchronous input lines |
| pinOut | output | 16 | Output line drive |
| irqOut | output | 1 | Level-high interrupt request |

## Verification
The clear write to offset 1 and a newly accepted input change can land on the same clock edge. The bench provokes this by first recording a change on the high input byte. It then toggles a low input line and times a write to offset 1 so that the write completes on the third edge after the toggle, the edge where the synchronized level is accepted. The bench judges the result by reading the status byte: the expected value is 0x05, because the high-byte flag is cleared while the new low-byte change survives and keeps irqOut high.

// File: rtl/dio16_pkg.sv
package dio16_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BYTES = 2;
  localparam int unsigned IO_W      = BYTE_W * NUM_BYTES;

  localparam logic [2:0] ADR_OUT_LO  = 3'd0;
  localparam logic [2:0] ADR_IN_LO   = 3'd1;
  localparam logic [2:0] ADR_IRQ_CTL = 3'd2;
  localparam logic [2:0] ADR_FLT_CTL = 3'd3;
  localparam logic [2:0] ADR_OUT_HI  = 3'd4;
  localparam logic [2:0] ADR_IN_HI   = 3'd5;
  localparam logic [2:0] ADR_STATUS  = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_BYTES-1:0] wrOut;
    logic                 filtOn;
  } dpStrobe_t;
endpackage

// File: rtl/dio16_datapath.sv
module dio16_datapath
  import dio16_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic [IO_W-1:0]      pinIn,
  output logic [IO_W-1:0]      outLatch,
  output logic [IO_W-1:0]      inStable,
  output logic [NUM_BYTES-1:0] edgeByte
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

  logic [IO_W-1:0] syncA, syncB, inNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) outLatch[b*BYTE_W +: BYTE_W] <= '0;
      else if (strb.wrOut[b]) outLatch[b*BYTE_W +: BYTE_W] <= wdata;
    end
    assign edgeByte[b] = |(inNext[b*BYTE_W +: BYTE_W] ^ inStable[b*BYTE_W +: BYTE_W]);
  end

  for (genvar i = 0; i < IO_W; i++) begin : g_filt
    logic [CW-1:0] runCnt;
    logic          differs;
    assign differs = syncB[i] ^ inStable[i];

    always_comb begin
      if (!strb.filtOn)              inNext[i] = syncB[i];
      else if (differs && runCnt == LIM) inNext[i] = syncB[i];
      else                           inNext[i] = inStable[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN || !strb.filtOn || !differs) runCnt <= '0;
      else if (runCnt != LIM)               runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) inStable <= '0;
    else       inStable <= inNext;
  end
endmodule

// File: rtl/dio16_control.sv
module dio16_control
  import dio16_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           busAddr,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic [NUM_BYTES-1:0] edgeByte,
  input  logic [IO_W-1:0]      outLatch,
  input  logic [IO_W-1:0]      inStable,
  output dpStrobe_t            strb,
  output logic [BYTE_W-1:0]    busRdata,
  output logic                 irqOut,
  output logic                 irqEn,
  output logic                 filtEn,
  output logic [NUM_BYTES-1:0] statByte
);
  logic clrHit, pending;

  assign clrHit = busWr && busAddr == ADR_IN_LO;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn  <= 1'b0;
      filtEn <= 1'b0;
    end else begin
      if (busRd && busAddr == ADR_IRQ_CTL)      irqEn <= 1'b1;
      else if (busWr && busAddr == ADR_IRQ_CTL) irqEn <= 1'b0;
      if (busRd && busAddr == ADR_FLT_CTL)      filtEn <= 1'b1;
      else if (busWr && busAddr == ADR_FLT_CTL) filtEn <= 1'b0;
    end
  end

  // a change accepted in the clear cycle survives the clear
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN) statByte[b] <= 1'b0;
      else       statByte[b] <= (statByte[b] && !clrHit) || (edgeByte[b] && irqEn);
    end
  end

  assign pending = |statByte;
  assign irqOut  = pending && irqEn;

  assign strb.wrOut[0] = busWr && busAddr == ADR_OUT_LO;
  assign strb.wrOut[1] = busWr && busAddr == ADR_OUT_HI;
  assign strb.filtOn   = filtEn;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_OUT_LO: busRdata = outLatch[BYTE_W-1:0];
      ADR_OUT_HI: busRdata = outLatch[IO_W-1:BYTE_W];
      ADR_IN_LO:  busRdata = inStable[BYTE_W-1:0];
      ADR_IN_HI:  busRdata = inStable[IO_W-1:BYTE_W];
      ADR_STATUS: busRdata = {5'd0, pending, statByte};
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/dio16_top.sv
module dio16_top
  import dio16_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busRd,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic [15:0] pinIn,
  output logic [15:0] pinOut,
  output logic        irqOut
);
  dpStrobe_t            strb;
  logic [IO_W-1:0]      inStable;
  logic [NUM_BYTES-1:0] edgeByte, statByte;
  logic                 irqEn, filtEn;

  dio16_datapath #(.FILT_LEN(FILT_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .pinIn(pinIn),
    .outLatch(pinOut), .inStable(inStable), .edgeByte(edgeByte)
  );

  dio16_control ctl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .edgeByte(edgeByte), .outLatch(pinOut), .inStable(inStable), .strb(strb),
    .busRdata(busRdata), .irqOut(irqOut), .irqEn(irqEn), .filtEn(filtEn),
    .statByte(statByte)
  );
endmodule

// File: rtl/dio16_chk.sv
module dio16_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  busAddr,
  input logic        busRd,
  input logic        busWr,
  input logic [15:0] pinOut,
  input logic        irqOut,
  input logic        irqEn,
  input logic        filtEn,
  input logic [1:0]  edgeByte,
  input logic [1:0]  statByte
);
  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd2) |=> (!irqEn && !irqOut));
  p_irq_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd2) |=> irqEn);
  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqEn);
  p_filt_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd3) |=> filtEn);
  p_filt_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd3) |=> !filtEn);
  p_no_record_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn && statByte == 2'b00) |=> statByte == 2'b00);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd1 && edgeByte == 2'b00) |=> statByte == 2'b00);
  // R2 and R8: outputs move only on writes to offsets 0 and 4
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOut) |-> $past(busWr && (busAddr == 3'd0 || busAddr == 3'd4)));
endmodule

bind dio16_top dio16_chk chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .pinOut(pinOut), .irqOut(irqOut), .irqEn(irqEn), .filtEn(filtEn),
  .edgeByte(edgeByte), .statByte(statByte)
);

// File: tb/dio16_top_tb_top.sv
`timescale 1ns/1ps
module dio16_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic        irqOut;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [15:0] mOut = '0, mIn = '0;
  logic        mIrqEn = 0, mFilt = 0;
  logic [1:0]  mStat = '0;

  always #2.5 clk = ~clk;

  dio16_top dut_i (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .irqOut(irqOut));

  function automatic logic [7:0] expStatus(logic [1:0] s);
    return {5'd0, |s, s};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(posedge clk); #1 busWr = 0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1;
    #1 d = busRdata;
    @(posedge clk); #1 busRd = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  task automatic setPins(logic [15:0] v);
    logic [15:0] diff;
    @(negedge clk); pinIn = v;
    diff = v ^ mIn;
    if (mIrqEn) mStat = mStat | {|diff[15:8], |diff[7:0]};
    mIn = v;
    idle(12);
  endtask

  task automatic checkAll(string tag);
    logic [7:0] d;
    busRead(3'd0, d); check({tag, " R2 out lo"}, {8'd0, d}, {8'd0, mOut[7:0]});
    busRead(3'd4, d); check({tag, " R2 out hi"}, {8'd0, d}, {8'd0, mOut[15:8]});
    busRead(3'd1, d); check({tag, " R3 in lo"}, {8'd0, d}, {8'd0, mIn[7:0]});
    busRead(3'd5, d); check({tag, " R3 in hi"}, {8'd0, d}, {8'd0, mIn[15:8]});
    busRead(3'd6, d); check({tag, " R6 status"}, {8'd0, d}, {8'd0, expStatus(mStat)});
    busRead(3'd7, d); check({tag, " R8 spare read"}, {8'd0, d}, 16'h0000);
    @(negedge clk);
    check({tag, " R2 pins"}, pinOut, mOut);
    check({tag, " R4 irq"}, {15'd0, irqOut}, {15'd0, mIrqEn && |mStat});
  endtask

  task automatic glitch(int bitIdx, int len);
    @(negedge clk); pinIn[bitIdx] = ~pinIn[bitIdx];
    idle(len);
    @(negedge clk); pinIn[bitIdx] = ~pinIn[bitIdx];
    idle(14);
  endtask

  initial begin
    logic [7:0] d;
    int seed;
    seed = $urandom(32'd777);
    idle(3);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOut", pinOut, 16'h0000);
    check("R1 irqOut", {15'd0, irqOut}, 16'h0000);
    busRead(3'd6, d); check("R1 status", {8'd0, d}, 16'h0000);

    // R2 output latches
    busWrite(3'd0, 8'hA5); mOut[7:0] = 8'hA5;
    busWrite(3'd4, 8'h3C); mOut[15:8] = 8'h3C;
    checkAll("dir");

    // R6 changes while disabled are not recorded
    setPins(16'h0081);
    checkAll("R6 disabled");

    // R4 enable, record both halves
    busRead(3'd2, d); mIrqEn = 1;
    setPins(16'h1080);
    checkAll("R6 both edges");
    // R4 disable keeps pending but drops irq
    busWrite(3'd2, 8'hFF); mIrqEn = 0;
    checkAll("R4 disabled");
    busRead(3'd2, d); mIrqEn = 1;
    busWrite(3'd1, 8'h00); mStat = 0;
    checkAll("R7 clear");

    // R7 clear and accepted change on the same edge
    setPins(16'h1280);
    check("R7 pre hi", {15'd0, irqOut}, 16'h0001);
    @(negedge clk); pinIn = 16'h1281;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = 3'd1; busWdata = 8'h5A; busWr = 1;
    @(posedge clk); #1 busWr = 0;
    mIn = 16'h1281; mStat = 2'b01;
    idle(4);
    busRead(3'd6, d); check("R7 same-edge status", {8'd0, d}, 16'h0005);
    checkAll("R7 same-edge");
    busWrite(3'd1, 8'h00); mStat = 0;

    // R5 filter on rejects a short pulse
    busRead(3'd3, d); mFilt = 1;
    glitch(3, 2);
    checkAll("R5 filtered glitch");
    // R5 filter off lets the same pulse through
    busWrite(3'd3, 8'h00); mFilt = 0;
    glitch(3, 2);
    mStat[0] = 1'b1;
    checkAll("R5 unfiltered glitch");
    busWrite(3'd1, 8'h00); mStat = 0;

    // R8 writes to 5, 6, 7 change nothing
    busWrite(3'd5, 8'hFF); busWrite(3'd6, 8'hFF); busWrite(3'd7, 8'hFF);
    checkAll("R8 dead writes");

    // random phase
    for (int n = 0; n < 150; n++) begin
      int op;
      logic [7:0] rv;
      op = $urandom_range(0, 9);
      rv = 8'($urandom);
      case (op)
        0: begin busWrite(3'd0, rv); mOut[7:0] = rv; end
        1: begin busWrite(3'd4, rv); mOut[15:8] = rv; end
        2: begin busRead(3'd2, d); mIrqEn = 1; end
        3: begin busWrite(3'd2, rv); mIrqEn = 0; end
        4: begin busRead(3'd3, d); mFilt = 1; end
        5: begin busWrite(3'd3, rv); mFilt = 0; end
        6, 7: setPins(16'($urandom));
        8: begin busWrite(3'd1, rv); mStat = 0; end
        default: busWrite(3'($urandom_range(5, 7)), rv);
      endcase
      idle(2);
      checkAll("rand");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule